// File: doc/BRIEF.md
# Microcoded Step Sequencer for an Accumulator CPU

This block is the control unit of a small accumulator machine with an 8-bit datapath. The instruction register supplies a 4-bit opcode, and the ALU supplies carry and zero flags. From these the block produces one control word per clock.

A step counter walks through up to five timing steps per instruction. A table indexed by opcode and step gives the strobes for each step: register loads and bus drives, memory read and write, ALU subtract select, program-counter increment and jump load, and halt. The two fetch steps are the same for every opcode. An execute sequence ends early through a step-reset bit carried in the word itself. The conditional jumps take their jump load from the flag value present at the edge that enters their execute step. A halt opcode freezes the block until reset.

The control word and the step counter are both registers and are loaded on the same edge, so the two can never disagree. The opcode and flags are sampled at the edge that enters the step they affect. The datapath must therefore present the new instruction-register value before the edge that leaves fetch step 1.

Top module: `ucode_sequencer`

## Requirements
- R1: During and directly after reset, `step` is 0, `halted` is 0 and `ctrlWord` is 16'h2002.
- R2: When no halt is pending, `step` advances by one per clock and wraps from 4 to 0.
- R3: Step 0 always carries 16'h2002 (bit 13 PC drive, bit 1 MAR load). Step 1 always carries 16'h1028 (bit 3 memory read, bit 5 IR load, bit 12 PC increment), whatever the opcode. Control bit map:
  - bit 0: halt
  - bit 1: MAR load
  - bit 2: memory write
  - bit 3: memory read
  - bit 4: IR operand drive
  - bit 5: IR load
  - bit 6: A load
  - bit 7: A drive
  - bit 8: ALU drive
  - bit 9: ALU subtract
  - bit 10: B load
  - bit 11: output load
  - bit 12: PC increment
  - bit 13: PC drive
  - bit 14: PC jump load
  - bit 15: step reset
- R4: If the word of the current step has bit 15 set, the next step is 0.
- R5: Execute words for steps 2, 3 and 4, by opcode:
  - 1 (load): 0012, 8048
  - 2 (add): 0012, 0408, 0140
  - 3 (subtract): 0012, 0408, 0340
  - 4 (store): 0012, 8084
  - 5 (load immediate): 8050
  - 6 (jump): C010
  - 14 (output): 8880
- R6: Opcode 7 sets step 2 to C010 if carry was high at the edge entering step 2, and to 8000 otherwise.
- R7: Opcode 8 sets step 2 to C010 if zero was high at the edge entering step 2, and to 8000 otherwise.
- R8: Opcode 0 and the unused opcodes 9 to 13 produce 8000 at step 2 and no other execute strobes.
- R9: Opcode 15 produces 0001 at step 2. From the next edge until reset, `halted` is 1, `step` is 0 and `ctrlWord` is 0, whatever the inputs.
- R10: `ctrlWord` and `step` change only on a rising clock edge. An opcode or flag change between edges shows no effect before the next edge.
- R11: No word asserts memory read and memory write together, and the jump load appears only in step 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Opcode from the instruction register |
| carryFlag | input | 1 | ALU carry flag |
| zeroFlag | input | 1 | ALU zero flag |
| ctrlWord | output | 16 | Registered control word, bit map in R3 |
| step | output | 3 | Current timing step, 0 to 4 |
| halted | output | 1 | High once a halt opcode has executed |

## Verification
The hardest case to reach is the one-cycle window where a conditional jump's flag is sampled. The flag must have the right value exactly at the edge into step 2, and it is ignored at every other edge. The random phase changes the flags every cycle and picks opcodes that align with instruction boundaries only by chance. The reference model therefore samples the flags at the same edge the design does, and directed runs hold each flag both high and low across whole instructions. A further directed case changes the opcode and flags right after the edge into step 2 to show that the word does not follow them. The halt freeze is also reached repeatedly: a halt opcode drawn at random triggers a reset after a few held cycles.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef struct packed {
    logic stepRst;
    logic pcJump;
    logic pcOut;
    logic pcInc;
    logic outIn;
    logic bIn;
    logic aluSub;
    logic aluOut;
    logic aOut;
    logic aIn;
    logic irIn;
    logic irOut;
    logic ramOut;
    logic ramIn;
    logic marIn;
    logic halt;
  } ctrl_t;

  typedef struct packed {
    logic loadWord;
    logic zeroWord;
  } seqStrobe_t;

  localparam int unsigned OP_NOP = 0;
  localparam int unsigned OP_LDA = 1;
  localparam int unsigned OP_ADD = 2;
  localparam int unsigned OP_SUB = 3;
  localparam int unsigned OP_STA = 4;
  localparam int unsigned OP_LDI = 5;
  localparam int unsigned OP_JMP = 6;
  localparam int unsigned OP_JC  = 7;
  localparam int unsigned OP_JZ  = 8;
  localparam int unsigned OP_OUT = 14;
  localparam int unsigned OP_HLT = 15;

  localparam int unsigned EXEC_FIRST = 2;

  function automatic ctrl_t rowFor(input int unsigned opc, input int unsigned st);
    ctrl_t w;
    w = '0;
    if (st == 0) begin
      w.pcOut = 1'b1;
      w.marIn = 1'b1;
    end else if (st == 1) begin
      w.ramOut = 1'b1;
      w.irIn   = 1'b1;
      w.pcInc  = 1'b1;
    end else if (st == 2) begin
      case (opc)
        OP_LDA, OP_ADD, OP_SUB, OP_STA: begin
          w.irOut = 1'b1;
          w.marIn = 1'b1;
        end
        OP_LDI: begin
          w.irOut = 1'b1; w.aIn = 1'b1; w.stepRst = 1'b1;
        end
        OP_JMP, OP_JC, OP_JZ: begin
          w.irOut = 1'b1; w.pcJump = 1'b1; w.stepRst = 1'b1;
        end
        OP_OUT: begin
          w.aOut = 1'b1; w.outIn = 1'b1; w.stepRst = 1'b1;
        end
        OP_HLT:  w.halt    = 1'b1;
        default: w.stepRst = 1'b1;
      endcase
    end else if (st == 3) begin
      case (opc)
        OP_LDA: begin
          w.ramOut = 1'b1; w.aIn = 1'b1; w.stepRst = 1'b1;
        end
        OP_ADD, OP_SUB: begin
          w.ramOut = 1'b1; w.bIn = 1'b1;
        end
        OP_STA: begin
          w.aOut = 1'b1; w.ramIn = 1'b1; w.stepRst = 1'b1;
        end
        default: w = '0;
      endcase
    end else if (st == 4) begin
      if (opc == OP_ADD || opc == OP_SUB) begin
        w.aluOut = 1'b1;
        w.aIn    = 1'b1;
        w.aluSub = (opc == OP_SUB);
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/useq_step_ctrl.sv
module useq_step_ctrl
  import useq_pkg::*;
#(
  parameter int STEP_COUNT = 5,
  localparam int STEP_W = $clog2(STEP_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wordHalt,
  input  logic              wordStepRst,
  output logic [STEP_W-1:0] step,
  output logic [STEP_W-1:0] nextStep,
  output logic              halted,
  output seqStrobe_t        strobe
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEP_COUNT - 1);

  logic [STEP_W-1:0] stepQ;
  logic              haltQ;

  always_comb begin
    if (wordStepRst || stepQ == LAST) nextStep = '0;
    else                              nextStep = stepQ + STEP_W'(1);
  end

  always_comb begin
    strobe.loadWord = !haltQ && !wordHalt;
    strobe.zeroWord = !haltQ &&  wordHalt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepQ <= '0;
      haltQ <= 1'b0;
    end else if (!haltQ) begin
      if (wordHalt) begin
        haltQ <= 1'b1;
        stepQ <= '0;
      end else begin
        stepQ <= nextStep;
      end
    end
  end

  assign step   = stepQ;
  assign halted = haltQ;

  p_step_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (!haltQ && !wordHalt && !wordStepRst && stepQ != LAST) |=> (stepQ == $past(stepQ) + STEP_W'(1)));

  p_step_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!haltQ && !wordHalt && stepQ == LAST) |=> (stepQ == '0));

  p_early_rst_r4: assert property (@(posedge clk) disable iff (rst)
    (!haltQ && wordStepRst) |=> (stepQ == '0));

  p_halt_enter_r9: assert property (@(posedge clk) disable iff (rst)
    (!haltQ && wordHalt) |=> haltQ);

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    haltQ |=> (haltQ && stepQ == '0));

endmodule

// File: rtl/useq_ucode_table.sv
module useq_ucode_table
  import useq_pkg::*;
#(
  parameter int OPC_W      = 4,
  parameter int STEP_COUNT = 5,
  localparam int STEP_W  = $clog2(STEP_COUNT),
  localparam int NUM_OPC = 1 << OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              carryFlag,
  input  logic              zeroFlag,
  input  logic [STEP_W-1:0] nextStep,
  input  seqStrobe_t        strobe,
  output ctrl_t             word
);

  ctrl_t romWord [NUM_OPC][STEP_COUNT];

  for (genvar o = 0; o < NUM_OPC; o++) begin : g_opc
    for (genvar s = 0; s < STEP_COUNT; s++) begin : g_step
      assign romWord[o][s] = rowFor(o, s);
    end
  end

  ctrl_t rawWord;
  ctrl_t gatedWord;
  ctrl_t wordQ;
  logic  isJc;
  logic  isJz;
  logic  jumpBlocked;

  assign rawWord     = romWord[opcode][nextStep];
  assign isJc        = (opcode == OPC_W'(OP_JC));
  assign isJz        = (opcode == OPC_W'(OP_JZ));
  assign jumpBlocked = (nextStep == STEP_W'(EXEC_FIRST)) &&
                       ((isJc && !carryFlag) || (isJz && !zeroFlag));

  always_comb begin
    gatedWord = rawWord;
    if (jumpBlocked) begin
      gatedWord         = '0;
      gatedWord.stepRst = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  wordQ <= romWord[0][0];
    else if (strobe.zeroWord) wordQ <= '0;
    else if (strobe.loadWord) wordQ <= gatedWord;
  end

  assign word = wordQ;

  p_word_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!strobe.loadWord && !strobe.zeroWord) |=> $stable(wordQ));

  p_halt_clear_r9: assert property (@(posedge clk) disable iff (rst)
    strobe.zeroWord |=> (wordQ == '0));

  p_no_blind_jump_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadWord && jumpBlocked) |=> (!wordQ.pcJump && wordQ.stepRst));

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import useq_pkg::*;
#(
  parameter int OPC_W      = 4,
  parameter int STEP_COUNT = 5,
  localparam int STEP_W = $clog2(STEP_COUNT),
  localparam int WORD_W = $bits(ctrl_t)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              carryFlag,
  input  logic              zeroFlag,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [STEP_W-1:0] step,
  output logic              halted
);

  ctrl_t             word;
  seqStrobe_t        strobe;
  logic [STEP_W-1:0] nextStep;

  useq_step_ctrl #(.STEP_COUNT(STEP_COUNT)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wordHalt   (word.halt),
    .wordStepRst(word.stepRst),
    .step       (step),
    .nextStep   (nextStep),
    .halted     (halted),
    .strobe     (strobe)
  );

  useq_ucode_table #(.OPC_W(OPC_W), .STEP_COUNT(STEP_COUNT)) u_table (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .carryFlag(carryFlag),
    .zeroFlag (zeroFlag),
    .nextStep (nextStep),
    .strobe   (strobe),
    .word     (word)
  );

  assign ctrlWord = word;

  p_fetch0_r3: assert property (@(posedge clk) disable iff (rst)
    (!halted && step == '0) |-> (word.pcOut && word.marIn && !word.irIn));

  p_fetch1_r3: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_W'(1)) |-> (word.ramOut && word.irIn && word.pcInc && !word.ramIn));

  p_halted_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halted |-> (word == '0));

  p_mem_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(word.ramIn && word.ramOut));

  p_jump_exec_r11: assert property (@(posedge clk) disable iff (rst)
    word.pcJump |-> (step == STEP_W'(EXEC_FIRST)));

endmodule

// File: tb/ucode_sequencer_tb.sv
module ucode_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = '0;
  logic        carryFlag = 1'b0;
  logic        zeroFlag = 1'b0;
  logic [15:0] ctrlWord;
  logic [2:0]  step;
  logic        halted;

  always #2 clk = ~clk;

  ucode_sequencer u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .carryFlag(carryFlag),
    .zeroFlag(zeroFlag), .ctrlWord(ctrlWord), .step(step), .halted(halted)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  int          mStep;
  bit          mHalt;
  logic [15:0] mWord;
  int          mOp;
  bit          mEarly;
  int          haltCycles;

  localparam logic [15:0] FETCH_A = 16'h2002;
  localparam logic [15:0] FETCH_B = 16'h1028;

  function automatic logic [15:0] expWord(int op, int st, bit c, bit z);
    if (st == 0) return FETCH_A;
    if (st == 1) return FETCH_B;
    if (st == 2) begin
      if (op == 1 || op == 2 || op == 3 || op == 4) return 16'h0012;
      if (op == 5)  return 16'h8050;
      if (op == 6)  return 16'hC010;
      if (op == 7)  return c ? 16'hC010 : 16'h8000;
      if (op == 8)  return z ? 16'hC010 : 16'h8000;
      if (op == 14) return 16'h8880;
      if (op == 15) return 16'h0001;
      return 16'h8000;
    end
    if (st == 3) begin
      if (op == 1) return 16'h8048;
      if (op == 2 || op == 3) return 16'h0408;
      if (op == 4) return 16'h8084;
      return 16'h0000;
    end
    if (op == 2) return 16'h0140;
    if (op == 3) return 16'h0340;
    return 16'h0000;
  endfunction

  function automatic string wordTag();
    if (mHalt) return "R9";
    if (mStep < 2) return "R3";
    if (mOp == 7) return "R6";
    if (mOp == 8) return "R7";
    if (mOp == 15) return "R9";
    if (mOp == 0 || (mOp >= 9 && mOp <= 13)) return "R8";
    return "R5";
  endfunction

  task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic checkNow();
    check(wordTag(), "ctrlWord", ctrlWord, mWord);
    check(mHalt ? "R9" : (mEarly ? "R4" : "R2"), "step", 16'(step), 16'(mStep));
    check("R9", "halted", 16'(halted), 16'(mHalt));
  endtask

  task automatic modelReset();
    mStep = 0; mHalt = 0; mWord = FETCH_A; mOp = 0; mEarly = 0;
  endtask

  task automatic modelAdvance(int op, bit c, bit z);
    if (mHalt) return;
    if (mWord[0]) begin
      mHalt = 1; mStep = 0; mWord = '0;
      return;
    end
    mEarly = mWord[15] && mStep != 4;
    mStep  = (mWord[15] || mStep == 4) ? 0 : mStep + 1;
    mWord  = expWord(op, mStep, c, z);
    mOp    = op;
  endtask

  // called at a falling edge
  task automatic tick(int op, bit c, bit z);
    checkNow();
    opcode = op[3:0]; carryFlag = c; zeroFlag = z;
    modelAdvance(op, c, z);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "reset step", 16'(step), 16'h0);
    check("R1", "reset halted", 16'(halted), 16'h0);
    check("R1", "reset ctrlWord", ctrlWord, FETCH_A);
    rst = 1'b0;
    modelReset();
    haltCycles = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seedSet;
    seedSet = $urandom(32'd4242);
    modelReset();
    @(negedge clk);
    doReset();

    // directed: every opcode held across whole instructions
    for (int op = 0; op < 15; op++) begin
      for (int k = 0; k < 6; k++) tick(op, 1'b0, 1'b0);
    end
    // R6 / R7 with each flag level
    for (int k = 0; k < 6; k++) tick(7, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) tick(7, 1'b0, 1'b1);
    for (int k = 0; k < 6; k++) tick(8, 1'b0, 1'b1);
    for (int k = 0; k < 6; k++) tick(8, 1'b1, 1'b0);

    // R10: inputs change just after the edge into step 2
    doReset();
    tick(5, 1'b0, 1'b0);
    checkNow();
    opcode = 4'd5; carryFlag = 1'b0; zeroFlag = 1'b0;
    modelAdvance(5, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    opcode = 4'd14; carryFlag = 1'b1; zeroFlag = 1'b1;
    @(negedge clk);
    check("R10", "ctrlWord after mid-cycle change", ctrlWord, 16'h8050);
    check("R10", "step after mid-cycle change", 16'(step), 16'h2);
    for (int k = 0; k < 4; k++) tick(7, 1'b1, 1'b1);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 15));
      tick(op, 1'($urandom), 1'($urandom));
      if (mHalt) begin
        haltCycles++;
        if (haltCycles >= 4) doReset();
      end
    end

    // R9 directed: halt then hold under changing inputs
    doReset();
    for (int k = 0; k < 3; k++) tick(15, 1'b0, 1'b0);
    check("R9", "halted after HLT", 16'(halted), 16'h1);
    for (int k = 0; k < 6; k++) tick(int'($urandom_range(0, 15)), 1'b1, 1'b1);
    check("R9", "word while halted", ctrlWord, 16'h0);
    doReset();
    tick(2, 1'b0, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule